// File: doc/BRIEF.md
# Video Stream Frame Control and Status Registers

This block sits beside a video streaming pipeline stage and gives software a small word-addressed register window onto it. A run bit decides whether the stage may take on new frames. Start and stop only take effect at frame boundaries, so a frame that has begun always completes. The datapath reports frame events as single-cycle strobes: start of frame, pixel valid, end of line and end of frame. The block returns one enable, `frame_go`. The datapath may only open a new frame on a start-of-frame strobe that arrives while `frame_go` is high.

While an accepted frame is in flight, the block counts pixels per line and lines per frame. At the end of the frame it compares these counts with the programmed width and height and records the result in a mismatch flag. It also keeps a sticky flag that is set once any frame has completed, a busy flag, and a field counter that software can clear. The busy flag has a low-latency variant: it rises on the first pixel of a frame and drops as soon as the programmed number of lines has arrived.

The register interface takes one-cycle write strobes. A read returns its data, with a valid pulse, exactly one cycle after the request.

Top module: `vid_ctl_regs`

## Requirements
- R1: Reads at byte offset 0x000 return 0x6AF7023D. Reads at 0x004 return the version word, with the map version in bits 7:0, the patch revision in 15:8, the update revision in 23:16 and the major revision in 31:24. Reads at 0x008 return the fixed conversion-mode code (0 to 5). Reads at 0x00C return 1 when debug features are built in and 0 otherwise.
- R2: A read request (`rd_en`) is answered one cycle later with `rvalid` high for that single cycle. Unmapped or reserved offsets read as zero.
- R3: The expected width (0x120) and expected height (0x124) keep bits 15:0 of the written data. The interlace code (0x128) keeps bits 3:0. All other bits of these registers read as zero.
- R4: Writes to read-only offsets, including the field counter at 0x144, change nothing.
- R5: After reset the run bit (0x154 bit 0) is 0 and `frame_go` is low. A start-of-frame strobe while stopped is not accepted: it produces no field count and no status change.
- R6: Writing 1 to 0x154 bit 0 raises `frame_go` in the next cycle. `frame_go` is low from the cycle after a frame is accepted until that frame's end-of-frame strobe.
- R7: Writing 0 to the run bit during a frame lets that frame finish and be counted. No further frame is accepted.
- R8: Writing 0 to the run bit while no frame is in progress drops `frame_go` in the next cycle.
- R9: The field counter at 0x144 increments by one at the end of each accepted frame.
- R10: Any write to 0x158 clears the field counter to zero, whatever the data. A clear in the same cycle as an end of frame wins over the increment.
- R11: Status (0x140) bit 1 sets at the end of the first accepted frame and stays set until reset.
- R12: Status bit 2 is updated at each end of frame. It is 1 when any line's pixel count differed from the expected width, or the frame's line count differed from the expected height. Otherwise it is 0.
- R13: With low-latency busy (the default), status bit 0 rises on the first pixel of an accepted frame. It falls on the end of line that completes the programmed number of lines, and stays 0 while extra lines are flushed and until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read response, one cycle after rd_en |
| sof | input | 1 | Start-of-frame strobe from the datapath |
| pix_vld | input | 1 | One pixel received |
| eol | input | 1 | End of line; may coincide with the line's last pixel |
| eof | input | 1 | End-of-frame strobe |
| frame_go | output | 1 | The datapath may accept a new frame |

## Verification
The assertions assume that frame strobes are well formed: a start of frame is followed by pixels and ends of line, then one end of frame, with no second start in between. They also assume that `rd_en` and `wr_en` are single-cycle pulses. The directed tasks keep to this. Each task drives one strobe per cycle, separated by idle cycles. Register accesses happen only between strobes, never in the same cycle as a frame event. Stop requests are made either between frames or with a frame open and no pixel pending. No start of frame is sent while a frame is open.

// File: rtl/vcsr_pkg.sv
package vcsr_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int DIM_W  = 16;
  localparam int ILC_W  = 4;

  localparam logic [ADDR_W-1:0] OFF_IDENT = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_REV   = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_MODE  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_DBG   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_XW    = 12'h120;
  localparam logic [ADDR_W-1:0] OFF_XH    = 12'h124;
  localparam logic [ADDR_W-1:0] OFF_ILACE = 12'h128;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h140;
  localparam logic [ADDR_W-1:0] OFF_FCNT  = 12'h144;
  localparam logic [ADDR_W-1:0] OFF_RUN   = 12'h154;
  localparam logic [ADDR_W-1:0] OFF_FCLR  = 12'h158;

  localparam logic [DATA_W-1:0] IDENT_WORD = 32'h6AF7_023D;

  typedef struct packed {
    logic [DIM_W-1:0] width;
    logic [DIM_W-1:0] height;
    logic [ILC_W-1:0] ilace;
  } fmt_cfg_t;

  // Pixels in a line including the one arriving with the end-of-line strobe.
  function automatic logic [DIM_W-1:0] line_len(input logic [DIM_W-1:0] seen, input logic px);
    return seen + {{(DIM_W-1){1'b0}}, px};
  endfunction

  // Frame verdict: any bad line or a wrong line total marks a mismatch.
  function automatic logic frame_bad(input logic any_bad_line,
                                     input logic [DIM_W-1:0] lines,
                                     input logic [DIM_W-1:0] exp_lines);
    return any_bad_line || (lines != exp_lines);
  endfunction
endpackage

// File: rtl/vcsr_run_ctrl.sv
module vcsr_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sof,
  input  logic eof,
  output logic frame_go,
  output logic in_frame,
  output logic frame_start,
  output logic frame_end
);
  logic open_q;

  assign frame_go    = run && !open_q;
  assign frame_start = sof && frame_go;
  assign frame_end   = open_q && eof;
  assign in_frame    = open_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           open_q <= 1'b0;
    else if (frame_start) open_q <= 1'b1;
    else if (frame_end)   open_q <= 1'b0;
  end
endmodule

// File: rtl/vcsr_frame_mon.sv
module vcsr_frame_mon
  import vcsr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit LOW_LAT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_frame,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             pix_vld,
  input  logic             eol,
  input  fmt_cfg_t         cfg,
  input  logic             cnt_clr,
  output logic             busy,
  output logic             done,
  output logic             mismatch,
  output logic [CNT_W-1:0] field_cnt
);
  logic [DIM_W-1:0] pix_q, line_q;
  logic             bad_q, busy_q, done_q, mis_q;
  logic [CNT_W-1:0] fcnt_q;

  logic             line_end, line_bad;
  logic [DIM_W-1:0] len_now, lines_now;

  assign line_end  = in_frame && eol;
  assign len_now   = line_len(pix_q, pix_vld);
  assign line_bad  = line_end && (len_now != cfg.width);
  assign lines_now = line_q + {{(DIM_W-1){1'b0}}, line_end};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
      bad_q  <= 1'b0;
    end else if (frame_start) begin
      pix_q  <= '0;
      line_q <= '0;
      bad_q  <= 1'b0;
    end else if (in_frame) begin
      if (line_end) begin
        pix_q  <= '0;
        line_q <= lines_now;
        bad_q  <= bad_q | line_bad;
      end else if (pix_vld) begin
        pix_q <= pix_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      mis_q  <= 1'b0;
    end else if (frame_end) begin
      done_q <= 1'b1;
      mis_q  <= frame_bad(bad_q | line_bad, lines_now, cfg.height);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         fcnt_q <= '0;
    else if (cnt_clr)   fcnt_q <= '0;
    else if (frame_end) fcnt_q <= fcnt_q + 1'b1;
  end

  generate
    if (LOW_LAT) begin : g_busy_ll
      logic lines_met, last_line;
      assign lines_met = line_q >= cfg.height;
      assign last_line = line_end && (lines_now == cfg.height);
      always_ff @(posedge clk) begin
        if (!rst_n)                        busy_q <= 1'b0;
        else if (frame_end || last_line)   busy_q <= 1'b0;
        else if (in_frame && pix_vld && !lines_met) busy_q <= 1'b1;
      end
    end else begin : g_busy_frame
      always_ff @(posedge clk) begin
        if (!rst_n)           busy_q <= 1'b0;
        else if (frame_start) busy_q <= 1'b1;
        else if (frame_end)   busy_q <= 1'b0;
      end
    end
  endgenerate

  assign busy      = busy_q;
  assign done      = done_q;
  assign mismatch  = mis_q;
  assign field_cnt = fcnt_q;
endmodule

// File: rtl/vcsr_regfile.sv
module vcsr_regfile
  import vcsr_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_WORD  = 32'h0101_0001,
  parameter int                MODE_CODE = 0,
  parameter bit                DEBUG_EN  = 1'b1,
  parameter int                CNT_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              busy,
  input  logic              done,
  input  logic              mismatch,
  input  logic [CNT_W-1:0]  field_cnt,
  output logic              run,
  output fmt_cfg_t          cfg,
  output logic              cnt_clr,
  output logic              run_wr
);
  localparam logic [DATA_W-1:0] MODE_WORD = DATA_W'(MODE_CODE);
  localparam logic [DATA_W-1:0] DBG_WORD  = DATA_W'(DEBUG_EN);

  logic              run_q;
  fmt_cfg_t          cfg_q;
  logic [DATA_W-1:0] rd_word, rdata_q;
  logic              rvalid_q;

  assign cnt_clr = wr_en && (addr == OFF_FCLR);
  assign run_wr  = wr_en && (addr == OFF_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_XW:    cfg_q.width  <= wdata[DIM_W-1:0];
        OFF_XH:    cfg_q.height <= wdata[DIM_W-1:0];
        OFF_ILACE: cfg_q.ilace  <= wdata[ILC_W-1:0];
        OFF_RUN:   run_q        <= wdata[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      OFF_IDENT: rd_word = IDENT_WORD;
      OFF_REV:   rd_word = REV_WORD;
      OFF_MODE:  rd_word = MODE_WORD;
      OFF_DBG:   rd_word = DBG_WORD;
      OFF_XW:    rd_word = DATA_W'(cfg_q.width);
      OFF_XH:    rd_word = DATA_W'(cfg_q.height);
      OFF_ILACE: rd_word = DATA_W'(cfg_q.ilace);
      OFF_STAT:  rd_word = {{(DATA_W-3){1'b0}}, mismatch, done, busy};
      OFF_FCNT:  rd_word = DATA_W'(field_cnt);
      OFF_RUN:   rd_word = {{(DATA_W-1){1'b0}}, run_q};
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      rdata_q  <= rd_en ? rd_word : '0;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
  assign run    = run_q;
  assign cfg    = cfg_q;
endmodule

// File: rtl/vid_ctl_regs.sv
module vid_ctl_regs
  import vcsr_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_WORD    = 32'h0101_0001,
  parameter int                MODE_CODE   = 0,
  parameter bit                DEBUG_EN    = 1'b1,
  parameter bit                LOW_LATENCY = 1'b1,
  parameter int                CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              sof,
  input  logic              pix_vld,
  input  logic              eol,
  input  logic              eof,
  output logic              frame_go
);
  logic             run_q, run_wr, cnt_clr;
  logic             in_frame, frame_start, frame_end;
  logic             busy, done, mismatch;
  logic [CNT_W-1:0] field_cnt;
  fmt_cfg_t         cfg;

  vcsr_regfile #(
    .REV_WORD(REV_WORD), .MODE_CODE(MODE_CODE), .DEBUG_EN(DEBUG_EN), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy), .done(done),
    .mismatch(mismatch), .field_cnt(field_cnt), .run(run_q), .cfg(cfg),
    .cnt_clr(cnt_clr), .run_wr(run_wr)
  );

  vcsr_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .run(run_q), .sof(sof), .eof(eof),
    .frame_go(frame_go), .in_frame(in_frame), .frame_start(frame_start),
    .frame_end(frame_end)
  );

  vcsr_frame_mon #(.CNT_W(CNT_W), .LOW_LAT(LOW_LATENCY)) u_mon (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .frame_start(frame_start),
    .frame_end(frame_end), .pix_vld(pix_vld), .eol(eol), .cfg(cfg),
    .cnt_clr(cnt_clr), .busy(busy), .done(done), .mismatch(mismatch),
    .field_cnt(field_cnt)
  );
endmodule

// File: rtl/vcsr_checker.sv
module vcsr_checker #(
  parameter int CNT_W   = 32,
  parameter bit LOW_LAT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             rvalid,
  input logic             run_wr,
  input logic [31:0]      wdata,
  input logic             frame_go,
  input logic             frame_start,
  input logic             frame_end,
  input logic             cnt_clr,
  input logic             pix_vld,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] field_cnt
);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_no_spurious_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  assert_go_drops_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_go);
  assert_idle_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_wr && !wdata[0]) |=> !frame_go);
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !cnt_clr) |=> (field_cnt == $past(field_cnt) + 1'b1));
  assert_count_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (field_cnt == '0));
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  assert_busy_on_pixel_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (LOW_LAT && $rose(busy)) |-> $past(pix_vld));
endmodule

bind vid_ctl_regs vcsr_checker #(.CNT_W(CNT_W), .LOW_LAT(LOW_LATENCY)) u_vcsr_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rvalid(rvalid), .run_wr(run_wr),
  .wdata(wdata), .frame_go(frame_go), .frame_start(frame_start),
  .frame_end(frame_end), .cnt_clr(cnt_clr), .pix_vld(pix_vld), .busy(busy),
  .done(done), .field_cnt(field_cnt)
);

// File: tb/vid_ctl_regs_bench.sv
module vid_ctl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] REV = 32'h0203_0405;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        sof = 1'b0, pix_vld = 1'b0, eol = 1'b0, eof = 1'b0;
  logic        frame_go;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;
  logic [31:0] rd_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_ctl_regs #(.REV_WORD(REV), .MODE_CODE(3), .DEBUG_EN(1'b1)) u_vid_ctl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .sof(sof), .pix_vld(pix_vld),
    .eol(eol), .eof(eof), .frame_go(frame_go)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    checks++;
    if (rvalid !== 1'b1) begin
      fails++;
      $display("FAIL R2 rvalid actual=%b expected=1", rvalid);
    end
    d = rdata;
  endtask

  task automatic ev(input logic s, input logic p, input logic e, input logic f);
    @(negedge clk); sof = s; pix_vld = p; eol = e; eof = f;
    @(negedge clk); sof = 0; pix_vld = 0; eol = 0; eof = 0;
  endtask

  task automatic send_lines(input int w, input int h, input int short_line);
    for (int l = 0; l < h; l++) begin
      int n = (l == short_line) ? w - 1 : w;
      for (int p = 0; p < n; p++) ev(0, 1, (p == n - 1), 0);
    end
  endtask

  task automatic send_frame(input int w, input int h, input int short_line);
    ev(1, 0, 0, 0);
    send_lines(w, h, short_line);
    ev(0, 0, 0, 1);
  endtask

  task automatic t_reset;
    chk("R5 frame_go after reset", {31'b0, frame_go}, 32'd0);
    chk("R2 rvalid idle", {31'b0, rvalid}, 32'd0);
    rd(12'h154, rd_val); chk("R5 run bit reset", rd_val, 32'd0);
    rd(12'h140, rd_val); chk("R11 status reset", rd_val, 32'd0);
    rd(12'h144, rd_val); chk("R9 count reset", rd_val, 32'd0);
  endtask

  task automatic t_constants;
    rd(12'h000, rd_val); chk("R1 ident", rd_val, 32'h6AF7_023D);
    rd(12'h004, rd_val); chk("R1 version", rd_val, REV);
    rd(12'h008, rd_val); chk("R1 mode", rd_val, 32'd3);
    rd(12'h00C, rd_val); chk("R1 debug", rd_val, 32'd1);
    rd(12'h200, rd_val); chk("R2 unmapped", rd_val, 32'd0);
    rd(12'h12C, rd_val); chk("R2 reserved", rd_val, 32'd0);
  endtask

  task automatic t_config;
    wr(12'h120, 32'hABCD_0004); rd(12'h120, rd_val); chk("R3 width", rd_val, 32'h0000_0004);
    wr(12'h124, 32'hFFFF_0003); rd(12'h124, rd_val); chk("R3 height", rd_val, 32'h0000_0003);
    wr(12'h128, 32'h0000_00F9); rd(12'h128, rd_val); chk("R3 interlace", rd_val, 32'h0000_0009);
    wr(12'h000, 32'h1234_5678); rd(12'h000, rd_val); chk("R4 ident write", rd_val, 32'h6AF7_023D);
  endtask

  task automatic t_stopped_sof;
    send_frame(4, 3, -1);
    rd(12'h144, rd_val); chk("R5 no count while stopped", rd_val, 32'd0);
    rd(12'h140, rd_val); chk("R5 no status while stopped", rd_val, 32'd0);
  endtask

  task automatic t_good_frame;
    wr(12'h154, 32'd1);
    chk("R6 go after start", {31'b0, frame_go}, 32'd1);
    ev(1, 0, 0, 0);
    chk("R6 go low in frame", {31'b0, frame_go}, 32'd0);
    send_lines(4, 3, -1);
    ev(0, 0, 0, 1);
    chk("R6 go back after frame", {31'b0, frame_go}, 32'd1);
    rd(12'h144, rd_val); chk("R9 count one", rd_val, 32'd1);
    rd(12'h140, rd_val); chk("R11 R12 status good", rd_val, 32'd2);
    wr(12'h144, 32'd77); rd(12'h144, rd_val); chk("R4 count write ignored", rd_val, 32'd1);
  endtask

  task automatic t_mismatch;
    send_frame(4, 3, 1);
    rd(12'h140, rd_val); chk("R12 short line", rd_val, 32'd6);
    send_frame(4, 3, -1);
    rd(12'h140, rd_val); chk("R12 clean again", rd_val, 32'd2);
    send_frame(4, 2, -1);
    rd(12'h140, rd_val); chk("R12 missing line", rd_val, 32'd6);
    rd(12'h144, rd_val); chk("R9 count four", rd_val, 32'd4);
  endtask

  task automatic t_busy;
    wr(12'h120, 32'd2); wr(12'h124, 32'd2);
    ev(1, 0, 0, 0);
    rd(12'h140, rd_val); chk("R13 busy idle before pixel", rd_val & 32'd1, 32'd0);
    ev(0, 1, 0, 0);
    rd(12'h140, rd_val); chk("R13 busy after first pixel", rd_val & 32'd1, 32'd1);
    ev(0, 1, 1, 0);
    rd(12'h140, rd_val); chk("R13 busy mid frame", rd_val & 32'd1, 32'd1);
    send_lines(2, 1, -1);
    rd(12'h140, rd_val); chk("R13 busy low at height", rd_val & 32'd1, 32'd0);
    send_lines(2, 1, -1);
    rd(12'h140, rd_val); chk("R13 busy low while flushing", rd_val & 32'd1, 32'd0);
    ev(0, 0, 0, 1);
    rd(12'h140, rd_val); chk("R12 extra line flagged", rd_val, 32'd6);
  endtask

  task automatic t_clear;
    wr(12'h158, 32'hDEAD_BEEF);
    rd(12'h144, rd_val); chk("R10 cleared", rd_val, 32'd0);
    rd(12'h140, rd_val); chk("R11 done stays", rd_val & 32'd2, 32'd2);
  endtask

  task automatic t_stop_in_frame;
    ev(1, 0, 0, 0);
    send_lines(2, 1, -1);
    wr(12'h154, 32'd0);
    chk("R7 go low after stop", {31'b0, frame_go}, 32'd0);
    send_lines(2, 1, -1);
    ev(0, 0, 0, 1);
    chk("R7 go stays low", {31'b0, frame_go}, 32'd0);
    rd(12'h144, rd_val); chk("R7 open frame counted", rd_val, 32'd1);
    send_frame(2, 2, -1);
    rd(12'h144, rd_val); chk("R7 no new frame", rd_val, 32'd1);
  endtask

  task automatic t_stop_idle;
    wr(12'h154, 32'd1);
    chk("R8 go before stop", {31'b0, frame_go}, 32'd1);
    wr(12'h154, 32'd0);
    chk("R8 go after idle stop", {31'b0, frame_go}, 32'd0);
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_constants();
    t_config();
    t_stopped_sof();
    t_good_frame();
    t_mismatch();
    t_busy();
    t_clear();
    t_stop_in_frame();
    t_stop_idle();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule